// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is a watchdog that counts operating ticks in a 10-bit up counter. When the counter rolls over, the block raises a reset request for the system. Software must clear the counter before the rollover to keep the system running. The timeout is 1024 operating ticks. At an operating tick rate of 256 Hz, that gives 4 seconds.

The operating tick is derived in two steps. First, one of four free-running tick enables is selected. The selected ticks are then passed through a power-of-two divider. The source and divider fields are guarded by a 16-bit key register: they accept writes only while the key register holds the unlock value.

A 4-bit run code starts and stops the counter. Only one code value stops it, so a corrupted bit will not normally disable the watchdog. A debug-run bit decides whether counting continues while the processor is halted for debug. Software uses a plain single-cycle register port. There is no data stream through the block, so the port has no valid/ready pair and never stalls: every write takes effect at the clock edge it is presented on, and read data is a combinational function of the address.

Top module: `wdog_top`

## Requirements
- R1: After reset, the key status (address 0, bit 0) reads 0, the clock configuration (address 1) reads 0, the control register (address 2) reads 0x000A with the counter stopped, the count (address 3) reads 0, and `rst_req` is low.
- R2: Writing 0x0096 to address 0 unlocks the block, and bit 0 of address 0 then reads 1. Writing any other value to address 0 locks it, and the bit then reads 0.
- R3: Address 1 holds the source select in bits [1:0] and the divider exponent in bits [5:4]. A write to address 1 changes these fields only while the block is unlocked. A write made while locked leaves the readback unchanged.
- R4: Address 2 bits [3:0] hold the run code. When the run code is 0xA, the count holds. For any other value, the count rises by one on each operating tick. The count reads from address 3 in bits [9:0].
- R5: Only the tick enable indexed by the source select feeds the counter. Pulses on the other tick enables leave the count unchanged.
- R6: With divider exponent d, one operating tick occurs per 2^d selected ticks. The divider phase restarts on every write to address 1.
- R7: On an operating tick taken at count 1023, the count wraps to 0 and `rst_req` is high for exactly one clock cycle.
- R8: Writing 1 to address 2 bit 4 makes the next operating tick set the count to 0 instead of adding one. This bit always reads back as 0.
- R9: While `dbg_halt` is high, counting stops if address 2 bit 8 is 0 and continues if that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| src_tick | input | 4 | Tick enables from the candidate clock sources |
| dbg_halt | input | 1 | Processor halted in debug mode |
| rst_req | output | 1 | One-cycle system reset request on overflow |

## Verification
The hardest state to reach from the ports is the overflow edge. It needs 1023 operating ticks delivered one at a time, with every clear, divider phase and debug freeze along the way accounted for exactly. If any step is off, the reset pulse lands on the wrong tick.

The stimulus first drives the count to a known value through a sequence of divided, stopped and debug-frozen phases. It then pulses the selected source exactly enough times to sit at 1023, confirms that no reset request has appeared, and sends one more tick. At that point the bench observes both the wrap to 0 and the width of the single-cycle `rst_req` pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0]  ADDR_KEY   = 2'd0;
  localparam logic [1:0]  ADDR_CFG   = 2'd1;
  localparam logic [1:0]  ADDR_CTRL  = 2'd2;
  localparam logic [1:0]  ADDR_COUNT = 2'd3;
  localparam logic [15:0] UNLOCK_KEY = 16'h0096;
  localparam logic [3:0]  STOP_CODE  = 4'hA;

  typedef struct packed {
    logic       dbg_run;
    logic [3:0] run_code;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int SRC_W = 2,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [SRC_W-1:0] src_sel,
  output logic [DIV_W-1:0] div_sel,
  output wdog_ctrl_t       ctrl,
  output logic             clr_set,
  output logic             cfg_wr
);
  localparam int DIV_LSB = 4;

  logic unlocked;
  logic key_wr, ctrl_wr;

  assign key_wr  = bus_wr && (bus_addr == ADDR_KEY);
  assign cfg_wr  = bus_wr && (bus_addr == ADDR_CFG) && unlocked;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign clr_set = ctrl_wr && bus_wdata[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (key_wr) begin
      unlocked <= (bus_wdata == UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= '0;
      div_sel <= '0;
    end else if (cfg_wr) begin
      src_sel <= bus_wdata[SRC_W-1:0];
      div_sel <= bus_wdata[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.run_code <= STOP_CODE;
      ctrl.dbg_run  <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl.run_code <= bus_wdata[3:0];
      ctrl.dbg_run  <= bus_wdata[8];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_KEY:  bus_rdata[0] = unlocked;
      ADDR_CFG: begin
        bus_rdata[SRC_W-1:0]          = src_sel;
        bus_rdata[DIV_LSB +: DIV_W]   = div_sel;
      end
      ADDR_CTRL: begin
        bus_rdata[3:0] = ctrl.run_code;
        bus_rdata[8]   = ctrl.dbg_run;
      end
      default:   bus_rdata[CNT_W-1:0] = cnt_val;
    endcase
  end

  AST_LOCKED_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(src_sel) && $stable(div_sel))); // R3
  AST_UNLOCK_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && bus_wdata == UNLOCK_KEY) |=> unlocked); // R2
endmodule

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
  parameter int SRC_N = 4,
  parameter int SRC_W = 2,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_tick,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             cfg_wr,
  output logic             op_tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             sel_tick;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;

  assign sel_tick = src_tick[src_sel];

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign pre_mask[i] = (i < int'(div_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (cfg_wr) begin
      pre_cnt <= '0;
    end else if (sel_tick) begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign op_tick = sel_tick && ((pre_cnt & pre_mask) == pre_mask);

  AST_TICK_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    op_tick |-> src_tick[src_sel]); // R5
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_tick && !cfg_wr) |=> $stable(pre_cnt)); // R6
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_tick,
  input  logic             run_en,
  input  logic             clr_set,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic clr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_pend <= 1'b0;
    end else if (op_tick && clr_pend) begin
      clr_pend <= 1'b0;
    end else if (clr_set) begin
      clr_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (op_tick && clr_pend) begin
        cnt <= '0;
      end else if (op_tick && run_en) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_MAX) rst_req <= 1'b1;
      end
    end
  end

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr_pend) |=> $stable(cnt)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_tick && run_en && !clr_pend) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_tick && clr_pend) |=> cnt == '0); // R8
  AST_RST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == '0); // R7
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int SRC_N = 4,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             dbg_halt,
  output logic             rst_req
);
  localparam int SRC_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  logic [SRC_W-1:0] src_sel;
  logic [DIV_W-1:0] div_sel;
  wdog_ctrl_t       ctrl;
  logic             clr_set, cfg_wr, op_tick, run_en;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.CNT_W(CNT_W), .SRC_W(SRC_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt),
    .src_sel(src_sel), .div_sel(div_sel), .ctrl(ctrl),
    .clr_set(clr_set), .cfg_wr(cfg_wr)
  );

  wdog_tickgen #(.SRC_N(SRC_N), .SRC_W(SRC_W), .DIV_W(DIV_W)) u_tickgen (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
    .div_sel(div_sel), .cfg_wr(cfg_wr), .op_tick(op_tick)
  );

  assign run_en = (ctrl.run_code != STOP_CODE) && (!dbg_halt || ctrl.dbg_run);

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .op_tick(op_tick), .run_en(run_en),
    .clr_set(clr_set), .cnt(cnt), .rst_req(rst_req)
  );

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !ctrl.dbg_run) |-> !run_en); // R9
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [3:0]  src_tick = 4'd0;
  logic        dbg_halt = 1'b0;
  logic        rst_req;

  logic        rd_strobe = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  int          n_checks = 0;
  int          n_fail = 0;
  int          rst_hi_cycles = 0;
  bit          done = 1'b0;

  wdog_top i_wdog_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .dbg_halt(dbg_halt), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops the expected item and compares a quarter period after the edge
  always @(posedge clk) begin
    if (rd_strobe) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        n_checks++;
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual 0x%04h expected 0x%04h", t, bus_rdata, e);
        end
      end
    end
  end

  always @(negedge clk) if (rst_req === 1'b1) rst_hi_cycles++;

  task automatic check_val(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected value, the monitor consumes it
  task automatic expect_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_tick[src] = 1'b1;
      @(negedge clk);
      src_tick[src] = 1'b0;
    end
  endtask

  task automatic set_cfg(input logic [15:0] v);
    bus_write(2'd0, 16'h0096);
    bus_write(2'd1, v);
    bus_write(2'd0, 16'h0000);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(2'd0, 16'h0000, "R1 key status");
    expect_rd(2'd1, 16'h0000, "R1 cfg");
    expect_rd(2'd2, 16'h000A, "R1 ctrl");
    expect_rd(2'd3, 16'h0000, "R1 count");
    check_val("R1 rst_req", int'(rst_req), 0);
    // R3 locked write ignored
    bus_write(2'd1, 16'h0013);
    expect_rd(2'd1, 16'h0000, "R3 locked cfg write");
    // R2 key
    bus_write(2'd0, 16'h1234);
    expect_rd(2'd0, 16'h0000, "R2 wrong key");
    bus_write(2'd0, 16'h0096);
    expect_rd(2'd0, 16'h0001, "R2 unlock");
    bus_write(2'd1, 16'h0001);
    expect_rd(2'd1, 16'h0001, "R2 cfg write unlocked");
    bus_write(2'd0, 16'h0000);
    expect_rd(2'd0, 16'h0000, "R2 relock");
    bus_write(2'd1, 16'h0032);
    expect_rd(2'd1, 16'h0001, "R3 cfg after relock");
    // R4 run code
    pulse(1, 5);
    expect_rd(2'd3, 16'd0, "R4 stopped");
    bus_write(2'd2, 16'h0005);
    pulse(1, 5);
    expect_rd(2'd3, 16'd5, "R4 running");
    // R5 other sources
    pulse(0, 3);
    pulse(2, 2);
    expect_rd(2'd3, 16'd5, "R5 unselected sources");
    bus_write(2'd2, 16'h000A);
    pulse(1, 3);
    expect_rd(2'd3, 16'd5, "R4 stop code holds");
    bus_write(2'd2, 16'h000B);
    pulse(1, 1);
    expect_rd(2'd3, 16'd6, "R4 near-stop code runs");
    bus_write(2'd2, 16'h0005);
    // R6 divider by 4
    set_cfg(16'h0021);
    pulse(1, 8);
    expect_rd(2'd3, 16'd8, "R6 divide by 4");
    pulse(1, 3);
    expect_rd(2'd3, 16'd8, "R6 partial period");
    set_cfg(16'h0001);
    // R8 clear
    bus_write(2'd2, 16'h0015);
    expect_rd(2'd2, 16'h0005, "R8 clear bit reads 0");
    expect_rd(2'd3, 16'd8, "R8 no tick yet");
    pulse(1, 1);
    expect_rd(2'd3, 16'd0, "R8 cleared on tick");
    pulse(1, 2);
    expect_rd(2'd3, 16'd2, "R8 counting after clear");
    // R9 debug halt
    dbg_halt = 1'b1;
    pulse(1, 3);
    expect_rd(2'd3, 16'd2, "R9 halted frozen");
    bus_write(2'd2, 16'h0105);
    pulse(1, 3);
    expect_rd(2'd3, 16'd5, "R9 debug run");
    dbg_halt = 1'b0;
    bus_write(2'd2, 16'h0005);
    // R7 overflow
    pulse(1, 1018);
    expect_rd(2'd3, 16'd1023, "R7 at max");
    check_val("R7 no early reset", rst_hi_cycles, 0);
    pulse(1, 1);
    expect_rd(2'd3, 16'd0, "R7 wrap");
    check_val("R7 one-cycle pulse", rst_hi_cycles, 1);
    pulse(1, 1);
    expect_rd(2'd3, 16'd1, "R7 after wrap");
    repeat (3) @(negedge clk);
    check_val("R7 pending items", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule